// File: doc/BRIEF.md
# Codec Register Access Controller

This block connects a processor bus to the command and status slots of a frame-based serial audio codec link. Software reaches the codec's 7-bit register space through an address window on the bus. The block turns bus writes in that window into codec write commands. Codec reads take two steps. A bus read of a codec register returns the value captured by the previous link read and starts a new link read. Software then waits for the read-done flag and reads again to collect the codec's answer. The serial shifting itself is left to a link framer, which takes one queued command in each frame-sync cycle and hands back responses as parallel address and data.

A lock bit arbitrates software access to the link. Reading the lock register returns its current value and then sets it, so a returned 0 means the caller now owns the link. Hardware releases the lock when a codec write is issued or a codec read completes. Software may also clear it by writing 0. Two sticky completion flags, one for writes and one for reads, are cleared by writing 1 to them. The status register also holds per-codec ready bits for a primary and a secondary codec. A read that gets no response with a matching address within four frame syncs is timed out and returns a fixed all-ones sentinel in the codec data field.

Top module: `codec_regacc_ctrl`

## Requirements
- R1: After reset the lock bit is 0, every status bit is 0, no command is queued (`cmd_valid`=0), and a codec-window read returns 0.
- R2: A read of the lock register (`bus_addr[7]`=0, `bus_addr[0]`=0) returns the lock bit in `bus_rdata[0]` and then sets the lock. A second read therefore returns 1.
- R3: A write to the lock register with `bus_wdata[0]`=0 clears the lock. A write with `bus_wdata[0]`=1 leaves it unchanged.
- R4: A bus write with `bus_addr[7]`=1 queues a codec write, with codec address `bus_addr[6:0]` and data `bus_wdata[15:0]`. The command appears on `cmd_*` with `cmd_rd`=0 and holds steady until the next `frm_sync`. That frame issues it, sets the write-done flag (status bit 0) and releases the lock.
- R5: A bus read with `bus_addr[7]`=1 returns the most recently captured link-read value. It also queues a read command with `cmd_rd`=1 and `cmd_addr` = `bus_addr[6:0]`.
- R6: While a read is outstanding, a response whose `rsp_addr` equals the requested address does three things: it captures `rsp_data` zero-extended, sets the read-done flag (status bit 1) and releases the lock. The next codec-window read returns that value.
- R7: A response with any other address is ignored. Nothing is captured, no flag is set, and the timeout keeps running.
- R8: If no matching response arrives by the fourth `frm_sync` after the read is issued, the captured value becomes 0x0000_FFFF, the read-done flag sets and the lock is released. Nothing happens after only three syncs.
- R9: A write to the status register (`bus_addr[7]`=0, `bus_addr[0]`=1) clears each flag whose `bus_wdata` bit is 1 (bit 0 write-done, bit 1 read-done). Bits written as 0 have no effect.
- R10: A codec-window access that arrives while a command is queued gets no `bus_ack` until that command is issued. Lock and status accesses are still acknowledged.
- R11: At most one command is issued per frame: `cmd_valid` falls in the cycle after the `frm_sync` that issues it.
- R12: Status bit 2 shows the primary codec ready bit and status bit 3 the secondary one. Each is sampled from `codec_rdy[0]` and `codec_rdy[1]` at every `frm_sync`, independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Bit 7 selects the codec window; bits 6:0 codec address; bit 0 alone selects lock/status otherwise |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access completes at the clock edge where this is high |
| frm_sync | input | 1 | One-cycle pulse at each frame boundary |
| codec_rdy | input | 2 | Ready reports: bit 0 primary, bit 1 secondary |
| cmd_valid | output | 1 | A command is queued for the next frame |
| cmd_rd | output | 1 | Queued command is a read |
| cmd_addr | output | 7 | Codec register address of the queued command |
| cmd_data | output | 16 | Write data of the queued command |
| rsp_valid | input | 1 | Status-slot response present this cycle |
| rsp_addr | input | 7 | Register address echoed in the response |
| rsp_data | input | 16 | Register data in the response |

## Verification
Directed sequences first try the access patterns that differ only in ordering: reading the lock twice, a codec access against a queued command, and a response that arrives with the wrong address. Together they separate a lock that sets on read from one that does not, a stall from a dropped command, and an address-checked capture from a blind one. Timeout runs count exactly three and then four frame syncs, with a wrong-address reply in between. This shows the boundary lies at the fourth sync and that stray replies do not stop the count. A seeded random mix of codec writes and reads follows, with random addresses, data, ready bits, response delays and timeouts, checked against a bench model of the captured value. This catches stale-data or field-mapping errors that the directed cases could miss.

// File: rtl/cra_pkg.sv
package cra_pkg;
   localparam int FLAG_WDONE = 0;
   localparam int FLAG_RDONE = 1;
   localparam int NUM_FLAGS  = 2;
   localparam int NUM_CODECS = 2;
   localparam logic SEL_LOCK = 1'b0;
   localparam logic SEL_STAT = 1'b1;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_LOCK_RD,
      ACC_LOCK_WR,
      ACC_STAT_RD,
      ACC_STAT_WR,
      ACC_CODEC_RD,
      ACC_CODEC_WR
   } acc_e;
endpackage

// File: rtl/cra_lock.sv
module cra_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic sw_clear,
   input  logic hw_release,
   output logic lock_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         lock_q <= 1'b0;
      else if (take)
         lock_q <= 1'b1;
      else if (sw_clear || hw_release)
         lock_q <= 1'b0;
   end
endmodule

// File: rtl/cra_flags.sv
module cra_flags #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[g] <= 1'b0;
         else if (set[g])
            q[g] <= 1'b1;
         else if (clr[g])
            q[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/cra_rdtrack.sv
module cra_rdtrack #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 16,
   parameter int BUS_DW     = 32,
   parameter int TMO_FRAMES = 4,
   localparam int CNT_W     = $clog2(TMO_FRAMES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_rd,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic              frm_sync,
   input  logic              rsp_valid,
   input  logic [ADDR_W-1:0] rsp_addr,
   input  logic [DATA_W-1:0] rsp_data,
   output logic [BUS_DW-1:0] rd_buf,
   output logic              rd_done,
   output logic [CNT_W-1:0]  tmo_cnt
);
   localparam logic [BUS_DW-1:0] SENTINEL = BUS_DW'({DATA_W{1'b1}});
   localparam logic [CNT_W-1:0]  LAST_TICK = CNT_W'(TMO_FRAMES - 1);

   logic              waiting_q;
   logic [ADDR_W-1:0] exp_addr_q;
   logic              match, tick, expire;

   assign match   = waiting_q && rsp_valid && (rsp_addr == exp_addr_q);
   assign tick    = waiting_q && frm_sync && !match;
   assign expire  = tick && (tmo_cnt == LAST_TICK);
   assign rd_done = match || expire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waiting_q  <= 1'b0;
         exp_addr_q <= '0;
         tmo_cnt    <= '0;
      end else if (issue_rd) begin
         waiting_q  <= 1'b1;
         exp_addr_q <= issue_addr;
         tmo_cnt    <= '0;
      end else if (rd_done) begin
         waiting_q  <= 1'b0;
         tmo_cnt    <= '0;
      end else if (tick) begin
         tmo_cnt    <= tmo_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_buf <= '0;
      else if (match)
         rd_buf <= BUS_DW'(rsp_data);
      else if (expire)
         rd_buf <= SENTINEL;
   end
endmodule

// File: rtl/codec_regacc_ctrl.sv
module codec_regacc_ctrl #(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 16,
   parameter int BUS_AW     = 8,
   parameter int BUS_DW     = 32,
   parameter int TMO_FRAMES = 4,
   localparam int CNT_W     = $clog2(TMO_FRAMES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              bus_ack,
   input  logic              frm_sync,
   input  logic [1:0]        codec_rdy,
   output logic              cmd_valid,
   output logic              cmd_rd,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] cmd_data,
   input  logic              rsp_valid,
   input  logic [ADDR_W-1:0] rsp_addr,
   input  logic [DATA_W-1:0] rsp_data
);
   import cra_pkg::*;

   if (BUS_AW < ADDR_W + 1) begin : g_bad_aw
      $error("BUS_AW must leave one bit above the codec address");
   end
   if (BUS_DW < DATA_W || BUS_DW < NUM_FLAGS + NUM_CODECS) begin : g_bad_dw
      $error("BUS_DW too narrow for codec data or status");
   end
   if (TMO_FRAMES < 1) begin : g_bad_tmo
      $error("TMO_FRAMES must be at least 1");
   end

   acc_e                  acc;
   logic                  win, issue, rd_done, lock_q;
   logic [NUM_FLAGS-1:0]  flag_set, flag_clr, flags_q;
   logic [NUM_CODECS-1:0] rdy_q;
   logic [BUS_DW-1:0]     rd_buf;
   logic [CNT_W-1:0]      tmo_cnt;
   logic                  unused_wdata;

   assign unused_wdata = ^bus_wdata[BUS_DW-1:DATA_W];

   // ---- bus decode and stall ----
   assign win     = bus_addr[BUS_AW-1];
   assign bus_ack = bus_req && !(win && cmd_valid);

   always_comb begin
      acc = ACC_NONE;
      if (bus_req && bus_ack) begin
         if (win)
            acc = bus_we ? ACC_CODEC_WR : ACC_CODEC_RD;
         else if (bus_addr[0] == SEL_LOCK)
            acc = bus_we ? ACC_LOCK_WR : ACC_LOCK_RD;
         else
            acc = bus_we ? ACC_STAT_WR : ACC_STAT_RD;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (win)
         bus_rdata = rd_buf;
      else if (bus_addr[0] == SEL_LOCK)
         bus_rdata = BUS_DW'(lock_q);
      else
         bus_rdata = BUS_DW'({rdy_q, flags_q});
   end

   // ---- single command slot toward the framer ----
   assign issue = frm_sync && cmd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_rd    <= 1'b0;
         cmd_addr  <= '0;
         cmd_data  <= '0;
      end else if (acc == ACC_CODEC_WR || acc == ACC_CODEC_RD) begin
         cmd_valid <= 1'b1;
         cmd_rd    <= (acc == ACC_CODEC_RD);
         cmd_addr  <= bus_addr[ADDR_W-1:0];
         cmd_data  <= (acc == ACC_CODEC_WR) ? bus_wdata[DATA_W-1:0] : '0;
      end else if (issue) begin
         cmd_valid <= 1'b0;
      end
   end

   // ---- read tracking with frame-sync timeout ----
   cra_rdtrack #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_DW(BUS_DW), .TMO_FRAMES(TMO_FRAMES)
   ) rdtrack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_rd  (issue && cmd_rd),
      .issue_addr(cmd_addr),
      .frm_sync  (frm_sync),
      .rsp_valid (rsp_valid),
      .rsp_addr  (rsp_addr),
      .rsp_data  (rsp_data),
      .rd_buf    (rd_buf),
      .rd_done   (rd_done),
      .tmo_cnt   (tmo_cnt)
   );

   // ---- access lock ----
   cra_lock lock_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (acc == ACC_LOCK_RD),
      .sw_clear  (acc == ACC_LOCK_WR && !bus_wdata[0]),
      .hw_release((issue && !cmd_rd) || rd_done),
      .lock_q    (lock_q)
   );

   // ---- sticky completion flags ----
   always_comb begin
      flag_set             = '0;
      flag_set[FLAG_WDONE] = issue && !cmd_rd;
      flag_set[FLAG_RDONE] = rd_done;
      flag_clr             = (acc == ACC_STAT_WR) ? bus_wdata[NUM_FLAGS-1:0] : '0;
   end

   cra_flags #(.N(NUM_FLAGS)) flags_i (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (flag_set),
      .clr  (flag_clr),
      .q    (flags_q)
   );

   // ---- per-codec ready capture ----
   for (genvar g = 0; g < NUM_CODECS; g++) begin : g_rdy
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdy_q[g] <= 1'b0;
         else if (frm_sync)
            rdy_q[g] <= codec_rdy[g];
      end
   end
endmodule

// File: rtl/cra_checker.sv
module cra_checker #(
   parameter int BUS_AW     = 8,
   parameter int TMO_FRAMES = 4,
   parameter int CNT_W      = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_we,
   input logic [BUS_AW-1:0] bus_addr,
   input logic [1:0]        bus_wdata_lo,
   input logic              bus_ack,
   input logic              frm_sync,
   input logic              cmd_valid,
   input logic              cmd_rd,
   input logic [6:0]        cmd_addr,
   input logic              lock_q,
   input logic [1:0]        flags_q,
   input logic [CNT_W-1:0]  tmo_cnt
);
   logic ctl_acc, lock_rd, stat_wr, wr_issue;
   assign ctl_acc  = bus_req && bus_ack && !bus_addr[BUS_AW-1];
   assign lock_rd  = ctl_acc && !bus_we && !bus_addr[0];
   assign stat_wr  = ctl_acc && bus_we && bus_addr[0];
   assign wr_issue = cmd_valid && !cmd_rd && frm_sync;

   assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_addr[BUS_AW-1] && cmd_valid |-> !bus_ack);

   assert_one_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && frm_sync |=> !cmd_valid);

   assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !frm_sync |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_rd));

   assert_wr_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_issue |=> flags_q[0]);

   assert_lock_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lock_rd |=> lock_q);

   assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr && bus_wdata_lo[0] && !wr_issue |=> !flags_q[0]);

   assert_tmo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_cnt < CNT_W'(TMO_FRAMES));
endmodule

bind codec_regacc_ctrl cra_checker #(
   .BUS_AW(BUS_AW), .TMO_FRAMES(TMO_FRAMES), .CNT_W(CNT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_req     (bus_req),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata_lo(bus_wdata[1:0]),
   .bus_ack     (bus_ack),
   .frm_sync    (frm_sync),
   .cmd_valid   (cmd_valid),
   .cmd_rd      (cmd_rd),
   .cmd_addr    (cmd_addr[6:0]),
   .lock_q      (lock_q),
   .flags_q     (flags_q),
   .tmo_cnt     (tmo_cnt)
);

// File: tb/codec_regacc_ctrl_tb.sv
module codec_regacc_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ack;
   logic        frm_sync = 1'b0;
   logic [1:0]  codec_rdy = '0;
   logic        cmd_valid, cmd_rd;
   logic [6:0]  cmd_addr;
   logic [15:0] cmd_data;
   logic        rsp_valid = 1'b0;
   logic [6:0]  rsp_addr = '0;
   logic [15:0] rsp_data = '0;

   int total = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   codec_regacc_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .frm_sync(frm_sync), .codec_rdy(codec_rdy),
      .cmd_valid(cmd_valid), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_data(rsp_data)
   );

   function automatic logic [7:0] lock_a();  return 8'h00; endfunction
   function automatic logic [7:0] stat_a();  return 8'h01; endfunction
   function automatic logic [7:0] codec_a(input logic [6:0] a); return {1'b1, a}; endfunction
   function automatic logic [31:0] exp_stat(input logic [1:0] rdy, input bit rd, input bit wr);
      return {28'b0, rdy, rd, wr};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_xfer(input logic we, input logic [7:0] a, input logic [31:0] wd,
                           output logic [31:0] rd);
      bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
      #1;
      while (!bus_ack) begin @(negedge clk); #1; end
      rd = bus_rdata;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic frame(input logic [1:0] rdy);
      frm_sync = 1'b1; codec_rdy = rdy;
      @(negedge clk);
      frm_sync = 1'b0;
   endtask

   task automatic respond(input logic [6:0] a, input logic [15:0] d);
      rsp_valid = 1'b1; rsp_addr = a; rsp_data = d;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, model;
      logic [1:0]  rdy_m;
      void'($urandom(32'h5eed_c0de));
      model = 0; rdy_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cmd_valid", {31'b0, cmd_valid}, 0);
      bus_xfer(0, stat_a(), 0, r); chk("R1 status", r, 0);
      // R2 lock taken by reading
      bus_xfer(0, lock_a(), 0, r); chk("R2 first lock read", r, 0);
      bus_xfer(0, lock_a(), 0, r); chk("R2 second lock read", r, 1);
      // R3 write 1 no effect, write 0 clears
      bus_xfer(1, lock_a(), 1, r);
      bus_xfer(0, lock_a(), 0, r); chk("R3 write one kept", r, 1);
      bus_xfer(1, lock_a(), 0, r);
      bus_xfer(0, lock_a(), 0, r); chk("R3 write zero clears", r, 0);

      // R1/R5 first codec read returns 0 and queues a read
      bus_xfer(0, codec_a(7'h26), 0, r); chk("R1 R5 first codec read", r, 0);
      chk("R5 cmd queued", {cmd_valid, cmd_rd, cmd_addr}, {1'b1, 1'b1, 7'h26});

      // R10 stall of codec access while pending; control regs still served
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = codec_a(7'h10); bus_wdata = 32'h1111;
      #1; chk("R10 stalled ack", {31'b0, bus_ack}, 0);
      @(negedge clk); chk("R10 still stalled", {31'b0, bus_ack}, 0);
      bus_req = 1'b0;
      chk("R10 pending command intact", {cmd_rd, cmd_addr}, {1'b1, 7'h26});
      bus_xfer(0, stat_a(), 0, r); chk("R10 status served", r, 0);

      // R11 issue clears cmd_valid
      frame(rdy_m);
      chk("R11 cmd dropped after issue", {31'b0, cmd_valid}, 0);

      // R7/R8 timeout with a stray response
      frame(rdy_m);
      respond(7'h27, 16'hDEAD);
      bus_xfer(0, stat_a(), 0, r); chk("R7 stray reply ignored", r, exp_stat(rdy_m, 0, 0));
      frame(rdy_m); frame(rdy_m);
      bus_xfer(0, stat_a(), 0, r); chk("R8 no timeout at three", r, exp_stat(rdy_m, 0, 0));
      frame(rdy_m);
      bus_xfer(0, stat_a(), 0, r); chk("R8 timeout at four", r, exp_stat(rdy_m, 1, 0));
      bus_xfer(0, lock_a(), 0, r); chk("R8 lock released", r, 0);
      // R9 W1C
      bus_xfer(1, stat_a(), 0, r);
      bus_xfer(0, stat_a(), 0, r); chk("R9 zero write no effect", r, exp_stat(rdy_m, 1, 0));
      bus_xfer(1, stat_a(), 2, r);
      bus_xfer(0, stat_a(), 0, r); chk("R9 one write clears", r, exp_stat(rdy_m, 0, 0));
      model = 32'h0000_FFFF;
      bus_xfer(0, codec_a(7'h26), 0, r); chk("R8 sentinel returned", r, model);

      // R6 matching response captured
      frame(rdy_m);
      respond(7'h26, 16'hBEEF);
      bus_xfer(0, stat_a(), 0, r); chk("R6 read done", r, exp_stat(rdy_m, 1, 0));
      bus_xfer(0, lock_a(), 0, r); chk("R6 lock released", r, 0);
      bus_xfer(1, stat_a(), 3, r);
      bus_xfer(0, codec_a(7'h26), 0, r); chk("R6 repeat read data", r, 32'h0000_BEEF);
      frame(rdy_m); repeat (4) frame(rdy_m);
      model = 32'h0000_FFFF;
      bus_xfer(1, stat_a(), 3, r);

      // R12 ready bits independent
      frame(2'b01); rdy_m = 2'b01;
      bus_xfer(0, stat_a(), 0, r); chk("R12 primary only", r, exp_stat(2'b01, 0, 0));
      frame(2'b10); rdy_m = 2'b10;
      bus_xfer(0, stat_a(), 0, r); chk("R12 secondary only", r, exp_stat(2'b10, 0, 0));

      // random mix
      bus_xfer(1, lock_a(), 0, r);
      for (int i = 0; i < 40; i++) begin
         logic [6:0]  a;
         logic [15:0] d;
         a = 7'($urandom); d = 16'($urandom);
         bus_xfer(0, lock_a(), 0, r); chk("R2 random acquire", r, 0);
         if ($urandom % 2 == 0) begin
            bus_xfer(1, codec_a(a), {16'hA5A5, d}, r);
            chk("R4 write cmd", {cmd_valid, cmd_rd, cmd_addr, cmd_data}, {1'b1, 1'b0, a, d});
            rdy_m = 2'($urandom);
            frame(rdy_m);
            bus_xfer(0, stat_a(), 0, r); chk("R4 write done", r, exp_stat(rdy_m, 0, 1));
         end else begin
            bus_xfer(0, codec_a(a), 0, r); chk("R5 random codec read", r, model);
            chk("R5 read cmd", {cmd_valid, cmd_rd, cmd_addr}, {1'b1, 1'b1, a});
            rdy_m = 2'($urandom);
            frame(rdy_m);
            if ($urandom % 3 != 0) begin
               repeat ($urandom % 3) frame(rdy_m);
               if ($urandom % 2 == 0) respond(a + 7'd1, ~d);
               respond(a, d);
               model = {16'h0, d};
            end else begin
               repeat (4) frame(rdy_m);
               model = 32'h0000_FFFF;
            end
            bus_xfer(0, stat_a(), 0, r); chk("R6 R8 random read done", r, exp_stat(rdy_m, 1, 0));
         end
         bus_xfer(1, stat_a(), 3, r);
         bus_xfer(0, stat_a(), 0, r); chk("R9 random clear", r, exp_stat(rdy_m, 0, 0));
      end
      bus_xfer(0, codec_a(7'h05), 0, r); chk("R6 final captured", r, model);

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule